// File: doc/BRIEF.md
# Lock Acquisition Time Differencer

This block sits in an on-chip event-processing path and turns raw lock-observation events into compact timing results. An upstream monitor reports two kinds of event for a lock-acquire routine. A call event is sent when the routine is entered, and it carries a timestamp and the address of the lock. A return event is sent when the routine exits, and it carries a timestamp only. The block holds the most recent call. When the next return arrives, it sends one result event that carries the elapsed time and a 16-bit digest of the lock address. Each result replaces two input events, so the event count on the path is halved.

Events travel as 16-bit words on a valid/ready stream, most significant word first, with a last flag on the final word of each event. Two counters report pairing errors. One counts returns that arrive with no call pending. The other counts calls that replace a call still waiting for its return. While a result is being sent, the input stalls, so no input word is lost. A build-time option selects whether an elapsed time too large for 16 bits clamps to the maximum or keeps only its low bits.

Top module: `lock_wait_meter`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and both error counters are 0.
- R2: A call event is exactly 7 words: type code 0x0A01, timestamp high half, timestamp low half, then the 64-bit lock address as four words, most significant first. A return event is exactly 3 words: type code 0x0A02, timestamp high half, timestamp low half. The event ends on the word that has in_last set.
- R3: A result event is 3 words: type code 0x0A10, elapsed time, lock digest. out_last is 1 on the third word only. While out_ready is low, out_valid, out_data and out_last hold their values.
- R4: The elapsed time is the return timestamp minus the call timestamp, taken modulo 2^32. With the default option, any difference above 0xFFFF is sent as 0xFFFF.
- R5: The lock digest is the XOR of the four 16-bit words of the call's lock address.
- R6: A return event that arrives while no call is pending produces no result, and orphan_cnt increases by 1.
- R7: A call event that arrives while another call is pending replaces it, and overwrite_cnt increases by 1. The next result uses the newer call's timestamp and address.
- R8: Sending a result clears the pending call, so a second return that follows it counts as an orphan.
- R9: An event with any other type code, or a call or return type code with the wrong word count, is consumed and has no effect. It produces no result, changes no counter and leaves a pending call in place.
- R10: in_ready is 0 while a result event is being sent. Input words offered back to back are all taken in order, with none dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 16 | Input event word |
| in_last | input | 1 | Marks the final word of an input event |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Downstream can take a result word |
| out_data | output | 16 | Result event word |
| out_last | output | 1 | Marks the final word of a result event |
| orphan_cnt | output | 8 | Number of returns seen with no call pending |
| overwrite_cnt | output | 8 | Number of calls that replaced a pending call |

## Verification
The checker watches a set of properties on every cycle. Result words hold still while the output is stalled. The last flag falls on the third result word and on no other. A parsed return never arrives while a result is still being sent. Each counter moves by exactly one step, only after a parsed event, and never in the same cycle a result starts. The values inside a result need a reference model, and only the bench's scenarios can show them. These are the elapsed time (including timestamp wrap and the clamp boundary at 0xFFFF and 0x10000), the digest, which call was kept after a replacement, and that malformed or foreign events leave a pending call untouched.

// File: rtl/lwm_pkg.sv
package lwm_pkg;
   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_CALL = 2'd1,
      EV_RET  = 2'd2
   } ev_kind_e;
endpackage

// File: rtl/lwm_parse.sv
module lwm_parse
   import lwm_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int TS_W   = 32,
   parameter int ADDR_W = 64,
   parameter logic [WORD_W-1:0] CALL_CODE = 'h0A01,
   parameter logic [WORD_W-1:0] RET_CODE  = 'h0A02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat,
   input  logic [WORD_W-1:0] word,
   input  logic              last,
   output ev_kind_e          kind_q,
   output logic [TS_W-1:0]   ts_q,
   output logic [ADDR_W-1:0] addr_q
);
   localparam int TS_WORDS   = TS_W / WORD_W;
   localparam int ADDR_WORDS = ADDR_W / WORD_W;
   localparam int CALL_LEN   = 1 + TS_WORDS + ADDR_WORDS;
   localparam int RET_LEN    = 1 + TS_WORDS;
   localparam int IDX_W      = $clog2(CALL_LEN + 1);
   localparam logic [IDX_W-1:0] IDX_MAX   = '1;
   localparam logic [IDX_W-1:0] CALL_END  = IDX_W'(CALL_LEN - 1);
   localparam logic [IDX_W-1:0] RET_END   = IDX_W'(RET_LEN - 1);
   localparam logic [IDX_W-1:0] TS_FIRST  = IDX_W'(1);
   localparam logic [IDX_W-1:0] TS_LAST   = IDX_W'(TS_WORDS);
   localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(TS_WORDS + ADDR_WORDS);

   logic [IDX_W-1:0]  idx_q;
   logic [WORD_W-1:0] type_q;
   logic [WORD_W-1:0] cur_type;

   assign cur_type = (idx_q == '0) ? word : type_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         type_q <= '0;
         kind_q <= EV_NONE;
         ts_q   <= '0;
         addr_q <= '0;
      end else begin
         kind_q <= EV_NONE;
         if (beat) begin
            if (idx_q == '0)
               type_q <= word;
            if (idx_q >= TS_FIRST && idx_q <= TS_LAST)
               ts_q <= (ts_q << WORD_W) | TS_W'(word);
            if (idx_q > TS_LAST && idx_q <= ADDR_LAST)
               addr_q <= (addr_q << WORD_W) | ADDR_W'(word);
            if (last) begin
               idx_q <= '0;
               if (cur_type == CALL_CODE && idx_q == CALL_END)
                  kind_q <= EV_CALL;
               else if (cur_type == RET_CODE && idx_q == RET_END)
                  kind_q <= EV_RET;
            end else if (idx_q != IDX_MAX) begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lwm_pair.sv
module lwm_pair
   import lwm_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int TS_W     = 32,
   parameter int ADDR_W   = 64,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ev_kind_e          kind,
   input  logic [TS_W-1:0]   ts_in,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              fire,
   output logic [WORD_W-1:0] delta,
   output logic [WORD_W-1:0] digest,
   output logic [CNT_W-1:0]  orphan_cnt,
   output logic [CNT_W-1:0]  overwrite_cnt
);
   localparam int ADDR_WORDS = ADDR_W / WORD_W;

   logic              pend_q;
   logic [TS_W-1:0]   call_ts_q;
   logic [WORD_W-1:0] call_dig_q;
   logic [WORD_W-1:0] fold;
   logic [TS_W-1:0]   diff;

   always_comb begin
      fold = '0;
      for (int i = 0; i < ADDR_WORDS; i++)
         fold = fold ^ addr_in[i*WORD_W +: WORD_W];
   end

   assign diff   = ts_in - call_ts_q;
   assign fire   = (kind == EV_RET) && pend_q;
   assign digest = call_dig_q;

   generate
      if (SATURATE) begin : g_clamp
         assign delta = (|diff[TS_W-1:WORD_W]) ? {WORD_W{1'b1}} : diff[WORD_W-1:0];
      end else begin : g_wrap
         assign delta = diff[WORD_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q        <= 1'b0;
         call_ts_q     <= '0;
         call_dig_q    <= '0;
         orphan_cnt    <= '0;
         overwrite_cnt <= '0;
      end else begin
         case (kind)
            EV_CALL: begin
               if (pend_q)
                  overwrite_cnt <= overwrite_cnt + 1'b1;
               pend_q     <= 1'b1;
               call_ts_q  <= ts_in;
               call_dig_q <= fold;
            end
            EV_RET: begin
               if (pend_q)
                  pend_q <= 1'b0;
               else
                  orphan_cnt <= orphan_cnt + 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/lwm_emit.sv
module lwm_emit #(
   parameter int WORD_W = 16,
   parameter logic [WORD_W-1:0] OUT_CODE = 'h0A10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] delta,
   input  logic [WORD_W-1:0] digest,
   input  logic              out_ready,
   output logic              busy,
   output logic [WORD_W-1:0] out_data,
   output logic              out_last
);
   logic [1:0]        sel_q;
   logic [WORD_W-1:0] delta_q;
   logic [WORD_W-1:0] dig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sel_q   <= '0;
         delta_q <= '0;
         dig_q   <= '0;
      end else if (load) begin
         busy    <= 1'b1;
         sel_q   <= '0;
         delta_q <= delta;
         dig_q   <= digest;
      end else if (busy && out_ready) begin
         if (sel_q == 2'd2)
            busy <= 1'b0;
         else
            sel_q <= sel_q + 1'b1;
      end
   end

   always_comb begin
      case (sel_q)
         2'd0:    out_data = OUT_CODE;
         2'd1:    out_data = delta_q;
         default: out_data = dig_q;
      endcase
   end

   assign out_last = busy && (sel_q == 2'd2);
endmodule

// File: rtl/lock_wait_meter.sv
module lock_wait_meter
   import lwm_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int TS_W     = 32,
   parameter int ADDR_W   = 64,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1,
   parameter logic [WORD_W-1:0] CALL_CODE = 'h0A01,
   parameter logic [WORD_W-1:0] RET_CODE  = 'h0A02,
   parameter logic [WORD_W-1:0] OUT_CODE  = 'h0A10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data,
   output logic              out_last,
   output logic [CNT_W-1:0]  orphan_cnt,
   output logic [CNT_W-1:0]  overwrite_cnt
);
   generate
      if (TS_W % WORD_W != 0 || ADDR_W % WORD_W != 0)
         $error("timestamp and address widths must be whole words");
      if (TS_W <= WORD_W)
         $error("timestamp must be wider than one word");
      if (CNT_W < 1)
         $error("counter width must be at least 1");
   endgenerate

   ev_kind_e          kind;
   logic [TS_W-1:0]   ts_w;
   logic [ADDR_W-1:0] addr_w;
   logic              fire;
   logic [WORD_W-1:0] delta;
   logic [WORD_W-1:0] digest;
   logic              busy;
   logic              beat;

   assign in_ready  = !busy;
   assign out_valid = busy;
   assign beat      = in_valid && in_ready;

   lwm_parse #(
      .WORD_W(WORD_W), .TS_W(TS_W), .ADDR_W(ADDR_W),
      .CALL_CODE(CALL_CODE), .RET_CODE(RET_CODE)
   ) u_parse (
      .clk(clk), .rst_n(rst_n), .beat(beat), .word(in_data), .last(in_last),
      .kind_q(kind), .ts_q(ts_w), .addr_q(addr_w)
   );

   lwm_pair #(
      .WORD_W(WORD_W), .TS_W(TS_W), .ADDR_W(ADDR_W),
      .CNT_W(CNT_W), .SATURATE(SATURATE)
   ) u_pair (
      .clk(clk), .rst_n(rst_n), .kind(kind), .ts_in(ts_w), .addr_in(addr_w),
      .fire(fire), .delta(delta), .digest(digest),
      .orphan_cnt(orphan_cnt), .overwrite_cnt(overwrite_cnt)
   );

   lwm_emit #(
      .WORD_W(WORD_W), .OUT_CODE(OUT_CODE)
   ) u_emit (
      .clk(clk), .rst_n(rst_n), .load(fire), .delta(delta), .digest(digest),
      .out_ready(out_ready), .busy(busy), .out_data(out_data), .out_last(out_last)
   );
endmodule

// File: rtl/lwm_checker.sv
module lwm_checker
   import lwm_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_data,
   input logic              out_last,
   input logic [CNT_W-1:0]  orphan_cnt,
   input logic [CNT_W-1:0]  overwrite_cnt,
   input ev_kind_e          kind
);
   logic [1:0] beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat_q <= '0;
      else if (out_valid && out_ready)
         beat_q <= out_last ? 2'd0 : beat_q + 1'b1;
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   assert_last_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_last |-> beat_q == 2'd2);

   assert_last_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && beat_q == 2'd2 |-> out_last);

   assert_no_ret_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      kind == EV_RET |-> !out_valid);

   assert_orphan_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      orphan_cnt != $past(orphan_cnt) |->
         orphan_cnt == CNT_W'($past(orphan_cnt) + 1'b1) && $past(kind) == EV_RET && !$rose(out_valid));

   assert_over_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overwrite_cnt != $past(overwrite_cnt) |->
         overwrite_cnt == CNT_W'($past(overwrite_cnt) + 1'b1) && $past(kind) == EV_CALL);
endmodule

bind lock_wait_meter lwm_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_lwm_checker (
   .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data), .out_last(out_last), .orphan_cnt(orphan_cnt),
   .overwrite_cnt(overwrite_cnt), .kind(kind)
);

// File: tb/test_lock_wait_meter.sv
`timescale 1ns/1ps
module test_lock_wait_meter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_data = '0;
   logic        in_last = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [15:0] out_data;
   logic        out_last;
   logic [7:0]  orphan_cnt;
   logic [7:0]  overwrite_cnt;

   always #10 clk = ~clk;

   lock_wait_meter i_lock_wait_meter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
      .orphan_cnt(orphan_cnt), .overwrite_cnt(overwrite_cnt)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit ended = 0;
   bit bp_en = 0;

   // reference model state
   logic [16:0] exp_q[$];
   logic [15:0] cur[$];
   bit          m_pend = 0;
   logic [31:0] m_ts = '0;
   logic [15:0] m_dig = '0;
   int          m_orph = 0;
   int          m_over = 0;
   int          out_pos = 0;
   int          n_evt = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_up();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      #3;
      out_ready = bp_en ? (((cyc * 7) % 5) < 3) : 1'b1;
      if (cyc == 150000) begin
         chk(1'b0, "watchdog", cyc, 0);
         finish_up();
      end
   end

   // model classification of one complete input event
   task automatic classify();
      logic [31:0] d;
      logic [15:0] dd;
      if (cur.size() == 7 && cur[0] == 16'h0A01) begin
         if (m_pend) m_over++;
         m_pend = 1;
         m_ts   = {cur[1], cur[2]};
         m_dig  = cur[3] ^ cur[4] ^ cur[5] ^ cur[6];
      end else if (cur.size() == 3 && cur[0] == 16'h0A02) begin
         if (m_pend) begin
            d  = {cur[1], cur[2]} - m_ts;
            dd = (d > 32'h0000FFFF) ? 16'hFFFF : d[15:0];
            exp_q.push_back({1'b0, 16'h0A10});
            exp_q.push_back({1'b0, dd});
            exp_q.push_back({1'b1, m_dig});
            m_pend = 0;
         end else begin
            m_orph++;
         end
      end
   endtask

   // compare against the model every clock, away from the active edge
   always @(negedge clk) begin
      logic [16:0] e;
      string tag;
      if (rst_n && !ended) begin
         if (out_valid) chk(!in_ready, "R10 in_ready during result", in_ready, 0);
         if (out_valid && out_ready) begin
            tag = (out_pos == 0) ? "R3 type word" : (out_pos == 1) ? "R4 elapsed word" : "R5 digest word";
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 unexpected result word", out_data, 0);
            end else begin
               e = exp_q.pop_front();
               chk({out_last, out_data} == e, tag, {out_last, out_data}, e);
            end
            if (out_last) begin out_pos = 0; n_evt++; end
            else out_pos++;
         end
         if (in_valid && in_ready) begin
            cur.push_back(in_data);
            if (in_last) begin
               classify();
               cur.delete();
            end
         end
      end
   end

   // drivers: called at posedge+3, return at posedge+3 after the word is taken
   task automatic put(input logic [15:0] d, input bit l);
      bit ok;
      in_valid = 1'b1; in_data = d; in_last = l;
      forever begin
         @(negedge clk); ok = in_ready;
         @(posedge clk); #3;
         if (ok) break;
      end
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic send_call(input logic [31:0] ts, input logic [63:0] a);
      put(16'h0A01, 0); put(ts[31:16], 0); put(ts[15:0], 0);
      put(a[63:48], 0); put(a[47:32], 0); put(a[31:16], 0); put(a[15:0], 1);
   endtask

   task automatic send_ret(input logic [31:0] ts);
      put(16'h0A02, 0); put(ts[31:16], 0); put(ts[15:0], 1);
   endtask

   task automatic drain();
      int k = 0;
      while ((exp_q.size() != 0 || out_valid) && k < 2000) begin
         @(posedge clk); #3; k++;
      end
      repeat (4) begin @(posedge clk); #3; end
   endtask

   task automatic check_counts(input string tag, input int e_orph, input int e_over, input int e_evt);
      @(negedge clk);
      chk(orphan_cnt == 8'(e_orph), {tag, " orphan_cnt"}, orphan_cnt, e_orph);
      chk(overwrite_cnt == 8'(e_over), {tag, " overwrite_cnt"}, overwrite_cnt, e_over);
      chk(n_evt == e_evt, {tag, " result count"}, n_evt, e_evt);
      chk(orphan_cnt == 8'(m_orph) && overwrite_cnt == 8'(m_over), {tag, " model counters"},
          {orphan_cnt, overwrite_cnt}, {8'(m_orph), 8'(m_over)});
      @(posedge clk); #3;
   endtask

   localparam logic [63:0] ADDR_A = 64'h1111_2222_4444_8888; // digest FFFF
   localparam logic [63:0] ADDR_B = 64'hDEAD_BEEF_0123_4567; // digest 2406

   initial begin
      repeat (3) @(posedge clk);
      #3;
      // R1: reset state
      chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
      chk(orphan_cnt == 0, "R1 orphan_cnt", orphan_cnt, 0);
      chk(overwrite_cnt == 0, "R1 overwrite_cnt", overwrite_cnt, 0);
      rst_n = 1'b1;
      @(posedge clk); #3;

      // R2 R4 R5: basic pair, delta 0x0234, digest FFFF
      send_call(32'h0000_1000, ADDR_A);
      send_ret(32'h0000_1234);
      drain();
      check_counts("R2", 0, 0, 1);

      // R4: timestamp wrap gives 0x20
      send_call(32'hFFFF_FFF0, ADDR_B);
      send_ret(32'h0000_0010);
      drain();
      // R4: clamp boundaries 0xFFFF, 0x10000, 0x12340
      send_call(32'h0, ADDR_A); send_ret(32'h0000_FFFF);
      send_call(32'h0, ADDR_A); send_ret(32'h0001_0000);
      send_call(32'h5, ADDR_B); send_ret(32'h0001_2345);
      drain();
      check_counts("R4", 0, 0, 5);

      // R6: return with nothing pending
      send_ret(32'h0000_0050);
      drain();
      check_counts("R6", 1, 0, 5);

      // R7: second call replaces the first
      send_call(32'h0000_0100, ADDR_A);
      send_call(32'h0000_0200, ADDR_B);
      send_ret(32'h0000_0250);
      drain();
      check_counts("R7", 1, 1, 6);

      // R8: pending cleared after a result
      send_ret(32'h0000_0300);
      drain();
      check_counts("R8", 2, 1, 6);

      // R9: foreign and malformed events leave the pending call alone
      send_call(32'h0000_0400, ADDR_A);
      put(16'h0BAD, 0); put(16'h0000, 0); put(16'h0999, 1);
      put(16'h0A01, 0); put(16'h7777, 0); put(16'h7777, 0); put(16'h7777, 0); put(16'h7777, 1);
      put(16'h0A02, 0); put(16'h0000, 0); put(16'h0001, 0); put(16'h0002, 1);
      put(16'h0A02, 1);
      send_ret(32'h0000_0480);
      drain();
      check_counts("R9", 2, 1, 7);

      // R3 R10: back-to-back traffic under output backpressure
      bp_en = 1;
      for (int i = 0; i < 20; i++) begin
         send_call(32'h0001_0000 * i + 32'h10, (i % 2) ? ADDR_A : ADDR_B);
         send_ret(32'h0001_0000 * i + 32'h10 + 32'(i * 977));
      end
      drain();
      bp_en = 0;
      check_counts("R10", 2, 1, 27);
      chk(exp_q.size() == 0, "R3 leftover expected words", exp_q.size(), 0);

      finish_up();
   end
endmodule